// File: doc/BRIEF.md
# Conversion Start Sequencer for a Successive-Approximation ADC

This block produces the start strobe for a successive-approximation converter and keeps the strobe inside the converter's timing rules. After reset, and after every supply-loss flag, it refuses to start anything for a fixed settling interval. Once that interval is over, it takes conversion requests from two sources: the rising edge of an external trigger, and an internal rate timer that runs while free-run mode is selected. Each accepted request becomes one start pulse of fixed width. The pulse returns low well before the converter's deadline for further transitions, and the line then stays low until the conversion has finished.

The converter's busy flag is brought into the clock domain through a two-flop synchronizer. When its falling edge is seen, the block issues a one-cycle ready strobe. If busy never falls within the allowed conversion time, a one-cycle timeout strobe is issued instead and the conversion is abandoned. Consecutive start edges are always at least a minimum period apart, which sets the throughput ceiling. A request that cannot be served is not stored: it only pulses a drop indicator. All timing values are parameters counted in system-clock cycles. With a 100 MHz clock the defaults are a 3-cycle pulse, a 2000-cycle holdoff, a 200-cycle period and a 160-cycle busy timeout.

Top module: `convstart_seq`

## Requirements
- R1: While `rst_i` is high, and in the cycle after it is released, `start_o`, `ready_o`, `drop_o` and `timeout_o` are all 0, and the block is in its holdoff interval.
- R2: No start edge occurs until HOLDOFF_CYC full cycles have passed after the last clock edge at which `rst_i` or `pwr_loss_i` was sampled high. A request made during that interval is dropped.
- R3: A request sampled at a clock edge while the block is idle drives `start_o` high right after that edge, for exactly PULSE_CYC cycles. It then stays low for the rest of the conversion.
- R4: Two rising edges of `start_o` are at least MIN_PERIOD_CYC cycles apart. No new start edge occurs while a conversion is still open, meaning it has ended in neither ready nor timeout.
- R5: A request that is not accepted (during holdoff, start pulse, conversion or period wait) raises `drop_o` for one cycle, in the cycle after the edge that sampled it. A dropped request is never served later.
- R6: A falling edge of `busy_i` observed after the start pulse has ended raises `ready_o` for one cycle. If busy is first sampled low at edge x, `ready_o` is high after edge x+2.
- R7: If no busy falling edge reaches the sequencer within BUSY_TMO_CYC cycles after the start pulse ends, `timeout_o` is high for one cycle and the conversion is abandoned. A falling edge detected on that last cycle wins: ready is issued and timeout is not.
- R8: `pwr_loss_i` sampled high at any edge aborts any conversion and restarts the holdoff. `start_o`, `ready_o` and `timeout_o` are 0 after that edge, and a request sampled at the same edge is dropped.
- R9: A request is a 0-to-1 change of `trig_i` between two consecutive edges. While `free_run_i` is high, the rate timer also requests once every RATE_CYC edges. A trigger edge and a timer request at the same edge count as one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pwr_loss_i | input | 1 | Supply-loss flag, synchronous; restarts holdoff |
| trig_i | input | 1 | External trigger; its rising edge is a request |
| free_run_i | input | 1 | Enables the internal rate timer |
| busy_i | input | 1 | Converter busy flag, asynchronous |
| start_o | output | 1 | Conversion start line |
| ready_o | output | 1 | One-cycle strobe when a conversion completes |
| drop_o | output | 1 | One-cycle strobe for each rejected request |
| timeout_o | output | 1 | One-cycle strobe when busy does not fall in time |

## Verification
Two collisions are provoked on purpose. In the first, the converter holds busy for exactly as long as it takes the synchronized falling edge to arrive on the final cycle of the timeout window. The bench's model then expects a ready strobe and no timeout. One cycle longer must produce the opposite. In the second, a trigger edge and a power-loss flag arrive at the same edge, and the bench expects a drop pulse, no start and a fresh holdoff. The model compares every output on every cycle, so any change in the priority between these events is caught.

// File: rtl/convstart_pkg.sv
package convstart_pkg;

    typedef enum logic [2:0] {
        ST_HOLDOFF = 3'd0,
        ST_IDLE    = 3'd1,
        ST_START   = 3'd2,
        ST_CONV    = 3'd3,
        ST_WAIT    = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic start;
        logic ready;
        logic drop;
        logic timeout;
    } seq_out_s;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int span_bits(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/convstart_busy_sync.sv
module convstart_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic busy_i,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], busy_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign fall_o = last_q & ~chain_q[STAGES-1];

    // R6: a detected falling edge never repeats on the next cycle
    assert_fall_single_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        fall_o |=> !fall_o)
        else $error("busy fall seen twice in a row");

endmodule

// File: rtl/convstart_req.sv
module convstart_req #(
    parameter int RATE_CYC = 250
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic trig_i,
    input  logic free_run_i,
    output logic req_o
);
    import convstart_pkg::*;

    localparam int RW = span_bits(RATE_CYC);

    logic trig_d_q;
    logic tick;

    always_ff @(posedge clk_i) begin
        if (rst_i) trig_d_q <= 1'b0;
        else       trig_d_q <= trig_i;
    end

    generate
        if (RATE_CYC > 1) begin : g_timer
            localparam logic [RW-1:0] RATE_LAST = RW'(RATE_CYC - 1);
            logic [RW-1:0] rate_q;
            always_ff @(posedge clk_i) begin
                if (rst_i || !free_run_i)  rate_q <= '0;
                else if (rate_q == RATE_LAST) rate_q <= '0;
                else                       rate_q <= rate_q + 1'b1;
            end
            assign tick = free_run_i && (rate_q == RATE_LAST);
        end else begin : g_every
            assign tick = free_run_i;
        end
    endgenerate

    assign req_o = (trig_i & ~trig_d_q) | tick;

endmodule

// File: rtl/convstart_fsm.sv
module convstart_fsm #(
    parameter int PULSE_CYC      = 3,
    parameter int HOLDOFF_CYC    = 2000,
    parameter int MIN_PERIOD_CYC = 200,
    parameter int BUSY_TMO_CYC   = 160
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     pwr_loss_i,
    input  logic                     req_i,
    input  logic                     busy_fall_i,
    output convstart_pkg::seq_out_s  out_o
);
    import convstart_pkg::*;

    localparam int CW = span_bits(max_of(max_of(HOLDOFF_CYC, MIN_PERIOD_CYC),
                                         max_of(BUSY_TMO_CYC, PULSE_CYC)));
    localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLDOFF_CYC - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] TMO_LAST   = CW'(BUSY_TMO_CYC - 1);
    localparam logic [CW-1:0] PER_OPEN   = CW'(MIN_PERIOD_CYC - 2);
    localparam logic [CW-1:0] PER_CAP    = CW'(MIN_PERIOD_CYC - 1);

    seq_state_e     state_q, state_n;
    logic [CW-1:0]  cnt_q, cnt_n;
    logic [CW-1:0]  per_q, per_n;
    seq_out_s       out_q, out_n;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q + 1'b1;
        per_n   = (per_q == PER_CAP) ? per_q : per_q + 1'b1;
        out_n   = '0;
        if (pwr_loss_i) begin
            state_n    = ST_HOLDOFF;
            cnt_n      = '0;
            out_n.drop = req_i;
        end else begin
            case (state_q)
                ST_HOLDOFF: begin
                    out_n.drop = req_i;
                    if (cnt_q == HOLD_LAST) begin
                        state_n = ST_IDLE;
                        cnt_n   = '0;
                    end
                end
                ST_IDLE: begin
                    cnt_n = '0;
                    if (req_i) begin
                        state_n     = ST_START;
                        per_n       = '0;
                        out_n.start = 1'b1;
                    end
                end
                ST_START: begin
                    out_n.drop = req_i;
                    if (cnt_q == PULSE_LAST) begin
                        state_n = ST_CONV;
                        cnt_n   = '0;
                    end else begin
                        out_n.start = 1'b1;
                    end
                end
                ST_CONV: begin
                    out_n.drop = req_i;
                    if (busy_fall_i) begin
                        out_n.ready = 1'b1;
                        state_n     = ST_WAIT;
                        cnt_n       = '0;
                    end else if (cnt_q == TMO_LAST) begin
                        out_n.timeout = 1'b1;
                        state_n       = ST_WAIT;
                        cnt_n         = '0;
                    end
                end
                ST_WAIT: begin
                    out_n.drop = req_i;
                    cnt_n      = '0;
                    if (per_q >= PER_OPEN) state_n = ST_IDLE;
                end
                default: begin
                    state_n = ST_HOLDOFF;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_HOLDOFF;
            cnt_q   <= '0;
            per_q   <= '0;
            out_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            per_q   <= per_n;
            out_q   <= out_n;
        end
    end

    assign out_o = out_q;

    // ---- checker state for the timing assertions ----
    localparam logic [CW:0] HOLD_CAP = (CW+1)'(HOLDOFF_CYC);
    localparam logic [CW:0] GAP_CAP  = (CW+1)'(MIN_PERIOD_CYC);
    logic [CW:0] hold_age_q, gap_q, hi_len_q;
    logic        start_prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hold_age_q   <= '0;
            gap_q        <= GAP_CAP;
            hi_len_q     <= '0;
            start_prev_q <= 1'b0;
        end else begin
            if (pwr_loss_i)              hold_age_q <= '0;
            else if (hold_age_q != HOLD_CAP + 1'b1) hold_age_q <= hold_age_q + 1'b1;
            if (out_q.start && !start_prev_q) gap_q <= 1;
            else if (gap_q != GAP_CAP)        gap_q <= gap_q + 1'b1;
            hi_len_q     <= out_q.start ? hi_len_q + 1'b1 : '0;
            start_prev_q <= out_q.start;
        end
    end

    // R2: a start edge only after the full holdoff
    assert_start_after_holdoff_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(out_q.start) |-> hold_age_q > HOLD_CAP)
        else $error("start edge inside holdoff");

    // R3: the pulse ends after exactly PULSE_CYC cycles unless power loss cut it
    assert_pulse_width_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(out_q.start) && !$past(pwr_loss_i)) |-> hi_len_q == (CW+1)'(PULSE_CYC))
        else $error("start pulse width wrong");

    // R4: start edges are spaced by the minimum period
    assert_min_gap_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(out_q.start) |-> gap_q >= GAP_CAP)
        else $error("start edges too close");

    // R5: a drop pulse always answers a request
    assert_drop_has_req_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        out_q.drop |-> $past(req_i))
        else $error("drop without request");

    // R7: ready and timeout never together
    assert_ready_xor_tmo_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !(out_q.ready && out_q.timeout))
        else $error("ready and timeout together");

    // R8: after power loss the active outputs are quiet
    assert_pwr_loss_quiet_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(pwr_loss_i) |-> (!out_q.start && !out_q.ready && !out_q.timeout))
        else $error("activity right after power loss");

endmodule

// File: rtl/convstart_seq.sv
module convstart_seq #(
    parameter int PULSE_CYC      = 3,
    parameter int HOLDOFF_CYC    = 2000,
    parameter int MIN_PERIOD_CYC = 200,
    parameter int BUSY_TMO_CYC   = 160,
    parameter int RATE_CYC       = 250,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pwr_loss_i,
    input  logic trig_i,
    input  logic free_run_i,
    input  logic busy_i,
    output logic start_o,
    output logic ready_o,
    output logic drop_o,
    output logic timeout_o
);
    import convstart_pkg::*;

    logic     req;
    logic     busy_fall;
    seq_out_s outs;

    convstart_req #(.RATE_CYC(RATE_CYC)) u_req (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .trig_i     (trig_i),
        .free_run_i (free_run_i),
        .req_o      (req)
    );

    convstart_busy_sync #(.STAGES(SYNC_STAGES)) u_busy (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .busy_i (busy_i),
        .fall_o (busy_fall)
    );

    convstart_fsm #(
        .PULSE_CYC      (PULSE_CYC),
        .HOLDOFF_CYC    (HOLDOFF_CYC),
        .MIN_PERIOD_CYC (MIN_PERIOD_CYC),
        .BUSY_TMO_CYC   (BUSY_TMO_CYC)
    ) u_fsm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .pwr_loss_i  (pwr_loss_i),
        .req_i       (req),
        .busy_fall_i (busy_fall),
        .out_o       (outs)
    );

    assign start_o   = outs.start;
    assign ready_o   = outs.ready;
    assign drop_o    = outs.drop;
    assign timeout_o = outs.timeout;

    // R6: ready strobes are single cycles
    assert_ready_single_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |=> !ready_o)
        else $error("ready longer than one cycle");

endmodule

// File: tb/convstart_seq_bench.sv
module convstart_seq_bench;
    localparam int P = 3, H = 2000, M = 200, T = 160, RT = 150;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1, pl = 1'b0, trig = 1'b0, fr = 1'b0, busy = 1'b0;
    logic start, ready, drop, tmo;

    convstart_seq #(.PULSE_CYC(P), .HOLDOFF_CYC(H), .MIN_PERIOD_CYC(M),
                    .BUSY_TMO_CYC(T), .RATE_CYC(RT), .SYNC_STAGES(2)) u_convstart_seq (
        .clk_i(clk), .rst_i(rst), .pwr_loss_i(pl), .trig_i(trig), .free_run_i(fr),
        .busy_i(busy), .start_o(start), .ready_o(ready), .drop_o(drop), .timeout_o(tmo));

    int n_cmp = 0, n_bad = 0;
    int edge_n = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, edge_n);
        end
    endtask

    // ---------------- reference model (event times) ----------------
    int hold_end = 0, acc_edge = 0, next_ok = 0, fr_run = 0;
    bit conv_open = 0, trig_prev = 0, h1 = 0, h2 = 0, h3 = 0;
    bit e_start = 0, e_ready = 0, e_drop = 0, e_tmo = 0;
    bit live = 0;

    always @(posedge clk) begin : ref_model
        bit req, fall, acc, tick, fin;
        int age;
        edge_n++;
        fall = h3 && !h2;
        tick = 0;
        if (!rst && fr) begin
            fr_run++;
            tick = (fr_run % RT) == 0;
        end else fr_run = 0;
        req = (trig && !trig_prev) || tick;
        e_start = 0; e_ready = 0; e_drop = 0; e_tmo = 0;
        if (rst || pl) begin
            e_drop = pl && !rst && req;
            hold_end = edge_n + H + 1;
            conv_open = 0;
            next_ok = 0;
        end else begin
            fin = 0;
            acc = req && edge_n >= hold_end && !conv_open && edge_n >= next_ok;
            e_drop = req && !acc;
            if (conv_open) begin
                age = edge_n - acc_edge;
                e_start = age < P;
                if (age > P && age <= P + T && fall) begin
                    e_ready = 1; fin = 1;
                end else if (age == P + T) begin
                    e_tmo = 1; fin = 1;
                end
                if (fin) begin
                    conv_open = 0;
                    next_ok = (edge_n + 2 > acc_edge + M) ? edge_n + 2 : acc_edge + M;
                end
            end
            if (acc) begin
                conv_open = 1;
                acc_edge = edge_n;
                e_start = 1;
            end
        end
        if (rst) begin
            trig_prev = 0; h1 = 0; h2 = 0; h3 = 0;
        end else begin
            trig_prev = trig; h3 = h2; h2 = h1; h1 = busy;
        end
        live = 1;
    end

    // ---------------- converter stand-in ----------------
    int conv_len = 120, busy_left = 0;
    bit start_seen = 0;
    always @(negedge clk) begin
        if (start === 1'b1 && !start_seen) busy_left = conv_len;
        start_seen = (start === 1'b1);
        busy = (busy_left > 0);
        if (busy_left > 0) busy_left--;
    end

    // ---------------- per-cycle comparison and monitors ----------------
    int rises = 0, drops = 0, readys = 0, tmos = 0, last_rise = -1, min_gap = 1000000;
    bit mon_prev = 0;
    always @(negedge clk) begin
        if (live && !done) begin
            check(start === e_start, "R3 start_o vs model", start, e_start);
            check(ready === e_ready, "R6 ready_o vs model", ready, e_ready);
            check(drop  === e_drop,  "R5 drop_o vs model",  drop,  e_drop);
            check(tmo   === e_tmo,   "R7 timeout_o vs model", tmo, e_tmo);
            if (start === 1'b1 && !mon_prev) begin
                rises++;
                if (last_rise >= 0 && edge_n - last_rise < min_gap) min_gap = edge_n - last_rise;
                last_rise = edge_n;
            end
            mon_prev = (start === 1'b1);
            if (drop === 1'b1)  drops++;
            if (ready === 1'b1) readys++;
            if (tmo === 1'b1)   tmos++;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trig();
        trig = 1'b1; @(negedge clk);
        trig = 1'b0; @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        int r0, d0, q0, t0;
        wait_n(5);
        // R1: reset state
        check(start === 1'b0, "R1 start in reset", start, 0);
        check(ready === 1'b0, "R1 ready in reset", ready, 0);
        check(drop  === 1'b0, "R1 drop in reset",  drop, 0);
        check(tmo   === 1'b0, "R1 timeout in reset", tmo, 0);
        rst = 1'b0;
        wait_n(1);
        check(start === 1'b0, "R1 start after release", start, 0);

        // R2: holdoff rejects
        wait_n(100);
        pulse_trig();
        wait_n(3);
        check(rises == 0, "R2 no start during holdoff", rises, 0);
        check(drops == 1, "R2 holdoff request dropped", drops, 1);

        // R3 / R6: normal conversion
        wait_n(H);
        pulse_trig();
        check(rises == 1, "R3 accepted start", rises, 1);
        wait_n(20);
        d0 = drops;
        pulse_trig();
        check(drops == d0 + 1, "R5 request during conversion dropped", drops, d0 + 1);
        wait_n(150);
        check(readys == 1, "R6 one ready per conversion", readys, 1);

        // R4: burst of trigger edges
        repeat (600) begin trig = ~trig; @(negedge clk); end
        trig = 1'b0;
        check(rises >= 3, "R4 burst served", rises, 3);
        check(min_gap >= M, "R4 start spacing", min_gap, M);
        wait_n(300);

        // R7: stuck busy -> timeout
        t0 = tmos; conv_len = 400;
        pulse_trig();
        wait_n(200);
        check(tmos == t0 + 1, "R7 timeout on stuck busy", tmos, t0 + 1);
        wait_n(400);

        // R7: busy fall lands on the last timeout cycle
        q0 = readys; t0 = tmos; conv_len = 160;
        pulse_trig();
        wait_n(250);
        check(readys == q0 + 1, "R7 coincident fall gives ready", readys, q0 + 1);
        check(tmos == t0, "R7 coincident fall gives no timeout", tmos, t0);

        // R7: one cycle later the timeout wins
        q0 = readys; t0 = tmos; conv_len = 161;
        pulse_trig();
        wait_n(250);
        check(tmos == t0 + 1, "R7 late fall times out", tmos, t0 + 1);
        check(readys == q0, "R7 late fall no ready", readys, q0);

        // R8: power loss mid-conversion together with a trigger
        conv_len = 120;
        pulse_trig();
        wait_n(40);
        d0 = drops; r0 = rises;
        pl = 1'b1; trig = 1'b1; @(negedge clk);
        pl = 1'b0; trig = 1'b0; @(negedge clk);
        check(drops == d0 + 1, "R8 trigger with power loss dropped", drops, d0 + 1);
        check(start === 1'b0, "R8 start low after power loss", start, 0);
        wait_n(H - 50);
        pulse_trig();
        check(rises == r0, "R8 holdoff restarted", rises, r0);
        wait_n(100);
        pulse_trig();
        check(rises == r0 + 1, "R8 start after new holdoff", rises, r0 + 1);
        wait_n(300);

        // R9: internal rate timer
        r0 = rises;
        fr = 1'b1;
        wait_n(1500);
        fr = 1'b0;
        check(rises - r0 >= 4, "R9 free-run starts", rises - r0, 4);
        check(min_gap >= M, "R4 spacing under free-run", min_gap, M);
        wait_n(300);
        finish_run();
    end

    initial begin
        #(4 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL R3 watchdog expired: actual %0d expected %0d", edge_n, 150000);
        finish_run();
    end

endmodule